// File: doc/BRIEF.md
# GPIO Edge Interrupt Source

This block turns one asynchronous input pin into a single interrupt request. The pin is brought into the clock domain by a chain of flip-flops. The synchronized level is then compared with its value one cycle earlier. A mode bit chooses what counts as an event: either one selected edge (rising or falling), or any change of level.

A detected event raises a sticky pending flag. The interrupt output is high whenever that flag is set and the event is enabled. Software clears the flag by writing a one to it. A small word-addressed register port gives access to the live input level, the two detection controls, the raw trigger, the pending flag and the enable bit. Every register carries its meaning in bit 0 and reads zero in all other bits.

Top module: `gpio_edge_irq`

## Requirements
- R1: After reset the mode, edge-select, enable and pending bits all read 0, and `irq` is low.
- R2: Offset 0x00 returns the synchronized pin level in bit 0, with all other bits 0. A change on `pin_in` shows there after the second rising clock edge. The register is read-only, and writes to it have no effect.
- R3: With mode 0 and edge-select 0, a rising edge on the pin sets pending and a falling edge does not.
- R4: With mode 0 and edge-select 1 (offset 0x08, bit 0), a falling edge sets pending and a rising edge does not.
- R5: With mode 1 (offset 0x04, bit 0), both rising and falling edges set pending, whatever the edge-select bit holds.
- R6: Offset 0x0C, bit 0, is the raw trigger. It is high in the one cycle between the synchronized level changing and pending being set, and low while the pin is steady. Writes to it have no effect.
- R7: Writing 1 to bit 0 of offset 0x10 clears pending. Writing 0 there leaves it unchanged.
- R8: If a trigger and a clearing write fall in the same cycle, pending ends up set.
- R9: `irq` is high exactly when both pending and enable (offset 0x14, bit 0) are 1. Setting enable while pending is already set raises `irq` after that write.
- R10: Further events that arrive while pending is set keep it at 1. A single clearing write then clears it, and it stays clear while the pin is steady.
- R11: Mode, edge-select and enable read back at their offsets. Offsets not listed here read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 1 | Asynchronous pin being watched |
| reg_we | input | 1 | Register write strobe, taken at the rising edge |
| reg_addr | input | AW | Byte offset of the register access |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data for `reg_addr`, combinational |
| irq | output | 1 | Interrupt request: pending and enabled |

## Verification
Each internal state of the block is visible at the ports within a fixed number of cycles, so a fault shows up quickly:
- A synchronizer of the wrong depth moves the input-register change and the one-cycle raw trigger away from the second and third clock edges after the pin moves. The bench samples exactly those cycles.
- A wrong detector choice leaves pending clear after an edge that should count, or sets it after one that should not, one cycle after the trigger.
- A faulty clear or set-priority path leaves pending, and therefore `irq`, wrong immediately after the write cycle.

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq #(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pin_in,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq
);
  localparam logic [AW-1:0] OFF_LVL  = AW'(8'h00);
  localparam logic [AW-1:0] OFF_MODE = AW'(8'h04);
  localparam logic [AW-1:0] OFF_EDGE = AW'(8'h08);
  localparam logic [AW-1:0] OFF_STAT = AW'(8'h0C);
  localparam logic [AW-1:0] OFF_PEND = AW'(8'h10);
  localparam logic [AW-1:0] OFF_EN   = AW'(8'h14);

  logic [SYNC_STAGES-1:0] sync_q;
  logic lvl, last_q, mode_q, edge_q, en_q, pend_q, hit, clr, rbit;

  assign lvl = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_in};
      last_q <= lvl;
    end

  assign hit = mode_q ? (lvl ^ last_q)
             : (edge_q ? (last_q & ~lvl) : (lvl & ~last_q));

  assign clr = reg_we && (reg_addr == OFF_PEND) && reg_wdata[0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mode_q <= 1'b0;
      edge_q <= 1'b0;
      en_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (reg_we && reg_addr == OFF_MODE) mode_q <= reg_wdata[0];
      if (reg_we && reg_addr == OFF_EDGE) edge_q <= reg_wdata[0];
      if (reg_we && reg_addr == OFF_EN)   en_q   <= reg_wdata[0];
      pend_q <= hit | (pend_q & ~clr);
    end

  always_comb
    case (reg_addr)
      OFF_LVL:  rbit = lvl;
      OFF_MODE: rbit = mode_q;
      OFF_EDGE: rbit = edge_q;
      OFF_STAT: rbit = hit;
      OFF_PEND: rbit = pend_q;
      OFF_EN:   rbit = en_q;
      default:  rbit = 1'b0;
    endcase

  assign reg_rdata = {{(DW-1){1'b0}}, rbit};
  assign irq = pend_q & en_q;
endmodule

// File: rtl/gpio_edge_irq_chk.sv
module gpio_edge_irq_chk #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_we,
  input logic [AW-1:0] reg_addr,
  input logic [DW-1:0] reg_wdata,
  input logic          irq,
  input logic          lvl,
  input logic          mode_q,
  input logic          edge_q,
  input logic          en_q,
  input logic          pend_q,
  input logic          hit
);
  logic clr_wr;
  assign clr_wr = reg_we && (reg_addr == AW'(8'h10)) && reg_wdata[0];

  p_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q && !edge_q && $rose(lvl)) |=> pend_q);

  p_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q && edge_q && $fell(lvl)) |=> pend_q);

  p_change_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && lvl != $past(lvl)) |=> pend_q);

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !hit) |=> !pend_q);

  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && hit) |=> pend_q);

  p_irq_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (pend_q && en_q));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !clr_wr) |=> pend_q);
endmodule

bind gpio_edge_irq gpio_edge_irq_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .irq(irq), .lvl(sync_q[SYNC_STAGES-1]),
  .mode_q(mode_q), .edge_q(edge_q), .en_q(en_q), .pend_q(pend_q), .hit(hit)
);

// File: tb/gpio_edge_irq_bench.sv
`timescale 1ns/1ps
module gpio_edge_irq_bench;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam logic [AW-1:0] A_LVL = 8'h00, A_MODE = 8'h04, A_EDGE = 8'h08,
                            A_STAT = 8'h0C, A_PEND = 8'h10, A_EN = 8'h14;

  logic clk = 1'b0, rst_n = 1'b0, pin_in = 1'b0, reg_we = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic irq;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  gpio_edge_irq #(.AW(AW), .DW(DW)) u_gpio_edge_irq (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  always #2.5 clk = ~clk;

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic settle();
    repeat (4) tick();
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] v);
    reg_addr = a; #0.1; v = reg_rdata;
  endtask

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_reg(input string tag, input logic [AW-1:0] a, input logic [DW-1:0] exp);
    logic [DW-1:0] v;
    rd(a, v);
    check(tag, v, exp);
  endtask

  task automatic pin_event(input logic nv, input logic exp, input string tag);
    pin_in = nv;
    tick(); tick();
    check_reg({tag, " raw trigger R6"}, A_STAT, DW'(exp));
    check_reg({tag, " pending not yet R6"}, A_PEND, 0);
    tick();
    check_reg({tag, " pending"}, A_PEND, DW'(exp));
    check_reg({tag, " trigger dropped R6"}, A_STAT, 0);
    wr(A_PEND, 1);
    check_reg({tag, " cleared R7"}, A_PEND, 0);
  endtask

  task automatic t_reset();
    check_reg("R1 mode", A_MODE, 0);
    check_reg("R1 edge", A_EDGE, 0);
    check_reg("R1 enable", A_EN, 0);
    check_reg("R1 pending", A_PEND, 0);
    check("R1 irq", DW'(irq), 0);
  endtask

  task automatic t_input();
    pin_in = 1'b1;
    tick();
    check_reg("R2 level one edge after", A_LVL, 0);
    tick();
    check_reg("R2 level two edges after", A_LVL, 1);
    wr(A_LVL, 0);
    check_reg("R2 write ignored", A_LVL, 1);
    check_reg("R3 rising set pending", A_PEND, 1);
    wr(A_PEND, 1);
    pin_in = 1'b0;
    settle();
    check_reg("R2 level low", A_LVL, 0);
    check_reg("R3 falling ignored", A_PEND, 0);
  endtask

  task automatic t_rise();
    pin_event(1'b1, 1'b1, "R3 rise");
    pin_event(1'b0, 1'b0, "R3 fall");
  endtask

  task automatic t_fall();
    wr(A_EDGE, 1);
    check_reg("R11 edge readback", A_EDGE, 1);
    pin_event(1'b1, 1'b0, "R4 rise");
    pin_event(1'b0, 1'b1, "R4 fall");
  endtask

  task automatic t_change();
    wr(A_MODE, 1);
    check_reg("R11 mode readback", A_MODE, 1);
    pin_event(1'b1, 1'b1, "R5 rise sel1");
    pin_event(1'b0, 1'b1, "R5 fall sel1");
    wr(A_EDGE, 0);
    pin_event(1'b1, 1'b1, "R5 rise sel0");
    pin_event(1'b0, 1'b1, "R5 fall sel0");
  endtask

  task automatic t_status_ro();
    wr(A_STAT, 1);
    check_reg("R6 status write ignored", A_STAT, 0);
    check_reg("R6 status write no pending", A_PEND, 0);
  endtask

  task automatic t_irq();
    wr(A_EN, 0);
    pin_in = 1'b1; settle();
    check_reg("R9 pending set", A_PEND, 1);
    check("R9 irq masked", DW'(irq), 0);
    wr(A_EN, 1);
    check("R9 irq after enable", DW'(irq), 1);
    check_reg("R11 enable readback", A_EN, 1);
    wr(A_EN, 0);
    check("R9 irq after disable", DW'(irq), 0);
    wr(A_EN, 1);
    wr(A_PEND, 1);
    check("R9 irq after clear", DW'(irq), 0);
  endtask

  task automatic t_write_zero();
    pin_in = 1'b0; settle();
    wr(A_PEND, 0);
    check_reg("R7 write 0 keeps pending", A_PEND, 1);
    check("R7 irq kept", DW'(irq), 1);
    wr(A_PEND, 32'hFFFF_FFFE);
    check_reg("R7 bit0 zero keeps pending", A_PEND, 1);
    wr(A_PEND, 1);
    check_reg("R7 clear", A_PEND, 0);
  endtask

  task automatic t_repeat();
    pin_in = 1'b1; settle();
    pin_in = 1'b0; settle();
    pin_in = 1'b1; settle();
    check_reg("R10 pending after repeats", A_PEND, 1);
    wr(A_PEND, 1);
    check_reg("R10 one clear", A_PEND, 0);
    settle();
    check_reg("R10 stays clear", A_PEND, 0);
    check("R10 irq low", DW'(irq), 0);
  endtask

  task automatic t_set_wins();
    pin_in = 1'b0;
    tick(); tick();
    wr(A_PEND, 1);
    check_reg("R8 set wins over clear", A_PEND, 1);
    wr(A_PEND, 1);
    check_reg("R8 later clear", A_PEND, 0);
  endtask

  task automatic t_unmapped();
    check_reg("R11 offset 0x18", 8'h18, 0);
    check_reg("R11 offset 0x1C", 8'h1C, 0);
    check_reg("R11 offset 0x40", 8'h40, 0);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_input();
    t_rise();
    t_fall();
    t_change();
    t_status_ro();
    t_irq();
    t_write_zero();
    t_repeat();
    t_set_wins();
    t_unmapped();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule